// File: doc/BRIEF.md
# Register Status Rename Table

This block is the architectural register file of a dynamically scheduled core, extended so that every register also remembers which execution station will write it next. When an instruction issues, the table answers two source lookups in the same cycle. For each source it returns either a usable value with a ready flag, or the nonzero tag of the station whose result the instruction must wait for. In the same cycle the issuing station's tag is written against the destination register. Any older producer of that register is thereby forgotten, which removes write-after-read and write-after-write ordering constraints.

The table also listens to the shared result broadcast bus. A register whose pending tag equals the broadcast tag takes the broadcast data and goes back to the idle state (tag zero). A result from a producer that has since been superseded by a younger writer is dropped. A source lookup that hits a register in the very cycle its producer broadcasts gets the broadcast data at once. Tag value zero is reserved to mean "no pending producer".

Top module: `reg_rename_table`

## Requirements
- R1: After reset every register has tag 0 and value 0, so both read ports report ready=1, tag=0, value=0 for any index.
- R2: Reading a register whose tag is 0 returns its stored value with ready=1 and tag output 0. The two read ports are independent. On each port, ready is 1 exactly when that port's tag output is 0.
- R3: With issueValid high, issueTag (nonzero) is recorded against issueDst from the next cycle on. Later reads of that register give ready=0 and that tag. A read in the issue cycle itself sees the state before the issue.
- R4: A broadcast (cdbValid=1) whose nonzero cdbTag equals a register's tag stores cdbData into that register and sets its tag to 0 from the next cycle. Registers with other tags are unchanged.
- R5: A broadcast whose tag differs from a register's current tag leaves that register's value and tag unchanged. This includes the result of a producer that was retagged away by a younger issue.
- R6: When a port reads a register in the same cycle that its tag is broadcast, the port returns cdbData with ready=1 and tag 0.
- R7: When an issue to a register coincides with a broadcast that matches that register's old tag, the register ends up holding the new issue tag.
- R8: A broadcast carrying tag 0 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction issues this cycle |
| issueDst | input | IDX_W | Destination register of the issuing instruction |
| issueTag | input | TAG_W | Station tag of the issuing instruction, must be nonzero |
| srcAIdx | input | IDX_W | First source register index |
| srcBIdx | input | IDX_W | Second source register index |
| srcAValue | output | DATA_W | Value for the first source (valid when srcAReady) |
| srcATag | output | TAG_W | Producer tag for the first source, 0 when ready |
| srcAReady | output | 1 | First source value is usable |
| srcBValue | output | DATA_W | Value for the second source (valid when srcBReady) |
| srcBTag | output | TAG_W | Producer tag for the second source, 0 when ready |
| srcBReady | output | 1 | Second source value is usable |
| cdbValid | input | 1 | Result broadcast present |
| cdbTag | input | TAG_W | Tag of the station broadcasting |
| cdbData | input | DATA_W | Broadcast result value |

## Verification
Several properties are checked on every cycle at the ports. Each port's ready flag must agree with its tag output. An issued tag must show up on the next lookup of that register, whatever broadcast happened alongside it. A register seen waiting must turn ready with exactly the broadcast data one cycle after its tag is broadcast. A waiting register must keep its tag while no matching broadcast or issue touches it. Other behaviours need a planned sequence, and only the directed scenarios show them. These are a stale result being dropped after a retag, the same-cycle forward on both ports, a zero-tag broadcast being ignored, and the issue-versus-broadcast collision.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // Strobes from the tag control to the value datapath
  typedef struct packed {
    logic fwdA;   // port A takes the broadcast data this cycle
    logic fwdB;   // port B takes the broadcast data this cycle
  } rrtStrobes_t;

endpackage

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
  import rrt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 4,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [IDX_W-1:0]    issueDst,
  input  logic [TAG_W-1:0]    issueTag,
  input  logic                cdbValid,
  input  logic [TAG_W-1:0]    cdbTag,
  input  logic [IDX_W-1:0]    srcAIdx,
  input  logic [IDX_W-1:0]    srcBIdx,
  output logic [TAG_W-1:0]    srcATag,
  output logic [TAG_W-1:0]    srcBTag,
  output logic                srcAReady,
  output logic                srcBReady,
  output logic [NUM_REGS-1:0] captureVec,
  output rrtStrobes_t         strobes
);

  localparam logic [TAG_W-1:0] NO_TAG = '0;

  logic [TAG_W-1:0] tagTable [NUM_REGS];
  logic             cdbLive;
  logic [TAG_W-1:0] rawTagA;
  logic [TAG_W-1:0] rawTagB;

  // Tag zero on the bus never matches anything
  assign cdbLive = cdbValid && (cdbTag != NO_TAG);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_tag
    logic issueHit;

    assign issueHit      = issueValid && (issueDst == IDX_W'(r));
    assign captureVec[r] = cdbLive && (tagTable[r] == cdbTag);

    // Rename at issue outranks the clear from a matching broadcast
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagTable[r] <= NO_TAG;
      end else if (issueHit) begin
        tagTable[r] <= issueTag;
      end else if (captureVec[r]) begin
        tagTable[r] <= NO_TAG;
      end
    end
  end

  assign rawTagA = tagTable[srcAIdx];
  assign rawTagB = tagTable[srcBIdx];

  always_comb begin
    strobes      = '0;
    strobes.fwdA = cdbLive && (rawTagA == cdbTag);
    strobes.fwdB = cdbLive && (rawTagB == cdbTag);
    srcATag      = strobes.fwdA ? NO_TAG : rawTagA;
    srcBTag      = strobes.fwdB ? NO_TAG : rawTagB;
    srcAReady    = (srcATag == NO_TAG);
    srcBReady    = (srcBTag == NO_TAG);
  end

endmodule

// File: rtl/rrt_datapath.sv
module rrt_datapath
  import rrt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] captureVec,
  input  rrtStrobes_t         strobes,
  input  logic [DATA_W-1:0]   cdbData,
  input  logic [IDX_W-1:0]    srcAIdx,
  input  logic [IDX_W-1:0]    srcBIdx,
  output logic [DATA_W-1:0]   srcAValue,
  output logic [DATA_W-1:0]   srcBValue
);

  logic [DATA_W-1:0] valTable [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_val
    always_ff @(posedge clk) begin
      if (!rstN) begin
        valTable[r] <= '0;
      end else if (captureVec[r]) begin
        valTable[r] <= cdbData;
      end
    end
  end

  // Same-cycle bypass of the broadcast into the read ports
  assign srcAValue = strobes.fwdA ? cdbData : valTable[srcAIdx];
  assign srcBValue = strobes.fwdB ? cdbData : valTable[srcBIdx];

endmodule

// File: rtl/reg_rename_table.sv
module reg_rename_table
  import rrt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic [$clog2(NUM_REGS)-1:0] issueDst,
  input  logic [TAG_W-1:0]           issueTag,
  input  logic [$clog2(NUM_REGS)-1:0] srcAIdx,
  input  logic [$clog2(NUM_REGS)-1:0] srcBIdx,
  output logic [DATA_W-1:0]          srcAValue,
  output logic [TAG_W-1:0]           srcATag,
  output logic                       srcAReady,
  output logic [DATA_W-1:0]          srcBValue,
  output logic [TAG_W-1:0]           srcBTag,
  output logic                       srcBReady,
  input  logic                       cdbValid,
  input  logic [TAG_W-1:0]           cdbTag,
  input  logic [DATA_W-1:0]          cdbData
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0] captureVec;
  rrtStrobes_t         strobes;

  rrt_ctrl #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueDst   (issueDst),
    .issueTag   (issueTag),
    .cdbValid   (cdbValid),
    .cdbTag     (cdbTag),
    .srcAIdx    (srcAIdx),
    .srcBIdx    (srcBIdx),
    .srcATag    (srcATag),
    .srcBTag    (srcBTag),
    .srcAReady  (srcAReady),
    .srcBReady  (srcBReady),
    .captureVec (captureVec),
    .strobes    (strobes)
  );

  rrt_datapath #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .captureVec (captureVec),
    .strobes    (strobes),
    .cdbData    (cdbData),
    .srcAIdx    (srcAIdx),
    .srcBIdx    (srcBIdx),
    .srcAValue  (srcAValue),
    .srcBValue  (srcBValue)
  );

endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [IDX_W-1:0]  issueDst,
  input logic [TAG_W-1:0]  issueTag,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic [IDX_W-1:0]  srcBIdx,
  input logic [DATA_W-1:0] srcAValue,
  input logic [TAG_W-1:0]  srcATag,
  input logic              srcAReady,
  input logic [TAG_W-1:0]  srcBTag,
  input logic              srcBReady,
  input logic              cdbValid,
  input logic [TAG_W-1:0]  cdbTag,
  input logic [DATA_W-1:0] cdbData
);

  // R2: ready flag and tag output agree on both ports
  p_ready_tag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcAReady == (srcATag == '0)) && (srcBReady == (srcBTag == '0)));

  // R3 and R7: the issued tag is visible on the next lookup, even if a broadcast of the old tag collided
  p_issue_tag_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(issueValid) && ($past(issueTag) != '0) &&
     (srcAIdx == $past(issueDst)) && !(cdbValid && (cdbTag == $past(issueTag))))
    |-> (!srcAReady && (srcATag == $past(issueTag))));

  // R4: a waiting register becomes ready with the broadcast data one cycle after its tag is broadcast
  p_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(rstN) &&
     (srcAIdx == $past(srcAIdx)) && (srcAIdx == $past(srcAIdx, 2)) &&
     !$past(srcAReady, 2) && $past(cdbValid) && ($past(cdbTag) == $past(srcATag, 2)) &&
     !$past(issueValid && (issueDst == srcAIdx)) &&
     !$past(issueValid && (issueDst == srcAIdx), 2))
    |-> (srcAReady && (srcAValue == $past(cdbData))));

  // R5: a waiting register keeps its tag while no matching broadcast or issue touches it
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (srcAIdx == $past(srcAIdx)) && !$past(srcAReady) &&
     !$past(issueValid && (issueDst == srcAIdx)) &&
     !(cdbValid && (cdbTag == $past(srcATag))))
    |-> (!srcAReady && (srcATag == $past(srcATag))));

endmodule

bind reg_rename_table rrt_checker #(
  .DATA_W (DATA_W),
  .TAG_W  (TAG_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueDst   (issueDst),
  .issueTag   (issueTag),
  .srcAIdx    (srcAIdx),
  .srcBIdx    (srcBIdx),
  .srcAValue  (srcAValue),
  .srcATag    (srcATag),
  .srcAReady  (srcAReady),
  .srcBTag    (srcBTag),
  .srcBReady  (srcBReady),
  .cdbValid   (cdbValid),
  .cdbTag     (cdbTag),
  .cdbData    (cdbData)
);

// File: tb/reg_rename_table_tb.sv
module reg_rename_table_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 32;
  localparam int DATA_W     = 32;
  localparam int TAG_W      = 4;
  localparam int IDX_W      = $clog2(NUM_REGS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              issueValid = 1'b0;
  logic [IDX_W-1:0]  issueDst = '0;
  logic [TAG_W-1:0]  issueTag = '0;
  logic [IDX_W-1:0]  srcAIdx = '0;
  logic [IDX_W-1:0]  srcBIdx = '0;
  logic [DATA_W-1:0] srcAValue;
  logic [TAG_W-1:0]  srcATag;
  logic              srcAReady;
  logic [DATA_W-1:0] srcBValue;
  logic [TAG_W-1:0]  srcBTag;
  logic              srcBReady;
  logic              cdbValid = 1'b0;
  logic [TAG_W-1:0]  cdbTag = '0;
  logic [DATA_W-1:0] cdbData = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_rename_table #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueDst(issueDst),
    .issueTag(issueTag), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAValue(srcAValue), .srcATag(srcATag), .srcAReady(srcAReady),
    .srcBValue(srcBValue), .srcBTag(srcBTag), .srcBReady(srcBReady),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic portA(input string req, input logic rdy, input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val);
    chk(req, "A.ready", 64'(srcAReady), 64'(rdy));
    chk(req, "A.tag", 64'(srcATag), 64'(tag));
    if (rdy) chk(req, "A.value", 64'(srcAValue), 64'(val));
  endtask

  task automatic portB(input string req, input logic rdy, input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val);
    chk(req, "B.ready", 64'(srcBReady), 64'(rdy));
    chk(req, "B.tag", 64'(srcBTag), 64'(tag));
    if (rdy) chk(req, "B.value", 64'(srcBValue), 64'(val));
  endtask

  // Inputs change at the falling edge; outputs are sampled 1 unit later
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    issueValid = 1'b0;
    cdbValid   = 1'b0;
  endtask

  task automatic settle(input int a, input int b);
    srcAIdx = IDX_W'(a);
    srcBIdx = IDX_W'(b);
    #1;
  endtask

  task automatic doIssue(input int dst, input int tag);
    issueValid = 1'b1;
    issueDst   = IDX_W'(dst);
    issueTag   = TAG_W'(tag);
  endtask

  task automatic doCdb(input int tag, input logic [DATA_W-1:0] data);
    cdbValid = 1'b1;
    cdbTag   = TAG_W'(tag);
    cdbData  = data;
  endtask

  task automatic loadReg(input int r, input int tag, input logic [DATA_W-1:0] data);
    doIssue(r, tag);
    step();
    doCdb(tag, data);
    step();
  endtask

  task automatic t_reset();
    settle(5, 17);
    portA("R1", 1'b1, '0, '0);
    portB("R1", 1'b1, '0, '0);
  endtask

  task automatic t_idleRead();
    loadReg(3, 1, 32'hA5A5_0003);
    loadReg(4, 2, 32'h5A5A_0004);
    settle(3, 4);
    portA("R2", 1'b1, '0, 32'hA5A5_0003);
    portB("R2", 1'b1, '0, 32'h5A5A_0004);
    settle(4, 3);
    portA("R2", 1'b1, '0, 32'h5A5A_0004);
    portB("R2", 1'b1, '0, 32'hA5A5_0003);
  endtask

  task automatic t_issue();
    doIssue(7, 5);
    settle(7, 3);
    portA("R3 pre-issue", 1'b1, '0, '0);
    step();
    settle(7, 3);
    portA("R3", 1'b0, TAG_W'(5), '0);
    portB("R3 other reg", 1'b1, '0, 32'hA5A5_0003);
  endtask

  task automatic t_writeback();
    doCdb(5, 32'hC0DE_0007);
    settle(8, 3);
    step();
    settle(7, 3);
    portA("R4", 1'b1, '0, 32'hC0DE_0007);
    portB("R4 untouched", 1'b1, '0, 32'hA5A5_0003);
  endtask

  task automatic t_stale();
    doIssue(9, 6);
    step();
    doIssue(9, 7);
    step();
    doCdb(6, 32'hDEAD_0006);
    settle(1, 2);
    step();
    settle(9, 2);
    portA("R5 stale dropped", 1'b0, TAG_W'(7), '0);
    doCdb(7, 32'hBEEF_0009);
    settle(1, 2);
    step();
    settle(9, 2);
    portA("R5 young result", 1'b1, '0, 32'hBEEF_0009);
  endtask

  task automatic t_forward();
    doIssue(10, 3);
    step();
    doCdb(3, 32'hF00D_000A);
    settle(10, 10);
    portA("R6", 1'b1, '0, 32'hF00D_000A);
    portB("R6", 1'b1, '0, 32'hF00D_000A);
    step();
    settle(10, 10);
    portA("R6 stored", 1'b1, '0, 32'hF00D_000A);
  endtask

  task automatic t_priority();
    doIssue(11, 4);
    step();
    doIssue(11, 8);
    doCdb(4, 32'h1234_000B);
    settle(11, 0);
    portA("R6 forward at collision", 1'b1, '0, 32'h1234_000B);
    step();
    settle(11, 0);
    portA("R7", 1'b0, TAG_W'(8), '0);
  endtask

  task automatic t_zeroTag();
    doCdb(0, 32'h0BAD_0BAD);
    settle(3, 0);
    portA("R8 same cycle", 1'b1, '0, 32'hA5A5_0003);
    step();
    settle(3, 11);
    portA("R8", 1'b1, '0, 32'hA5A5_0003);
    portB("R8 waiting reg", 1'b0, TAG_W'(8), '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_idleRead();
    t_issue();
    t_writeback();
    t_stale();
    t_forward();
    t_priority();
    t_zeroTag();
    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule